// File: doc/BRIEF.md
# I2C Slave Byte Engine with Automatic Acknowledge

This block is an I2C bus target. It samples SCL and SDA with the system clock and finds START, repeated START and STOP conditions on the bus. It compares the first byte of each transfer with a 7-bit own address. Once it is addressed, it moves whole bytes between the bus and a simple user-side interface.

As a receiver, the block acknowledges its own address and every data byte without being asked. Each received byte appears on the user side as a one-cycle strobe with the byte beside it. As a transmitter, it raises a one-cycle request for each byte it needs. It takes the byte from a data input at the SCL falling edge that ends the preceding acknowledge clock. When the master answers a byte with a not-acknowledge, that byte was the last one. The engine then lets go of SDA.

A busy flag is high from the moment the own address is matched until the bus shows a STOP or a fresh START. The flag stays high through the idle period that follows a not-acknowledge. SDA is open-drain: the block only ever pulls the line low.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset, sda_oe, busy, rx_valid and tx_req are all low.
- R2: The first byte after a START is taken MSB first. Its upper seven bits are the address and bit 0 is the direction (1 = the master reads, 0 = the master writes). The slave pulls SDA low in the ninth clock only when the address equals own_addr.
- R3: In a write transfer, each data byte appears on rx_data, MSB first, with rx_valid high for exactly one cycle. Every data byte is acknowledged, the last one included.
- R4: An acknowledge from the slave starts after the eighth SCL falling edge. SDA stays low for the whole high phase of the ninth SCL pulse. sda_oe never changes while SCL is high.
- R5: In a read transfer, tx_req pulses once when the address is matched and once more for each byte the master acknowledges. The byte on tx_data at the SCL falling edge that ends the acknowledge clock is sent MSB first.
- R6: After the master answers a byte with not-acknowledge, the slave raises no further tx_req and keeps SDA released. busy stays high.
- R7: busy is high from the address acknowledge until a STOP or START is detected, and low at all other times.
- R8: A repeated START at any point returns the slave to address reception. The new address and direction then decide the next transfer.
- R9: After an address mismatch, the slave ignores all bus traffic until the next START or STOP: no acknowledge, no rx_valid. A STOP in the middle of a byte returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Slave address to match |
| scl_in | input | 1 | SCL line as seen on the pad |
| sda_in | input | 1 | SDA line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte |
| tx_req | output | 1 | One-cycle request for the next byte to send |
| tx_data | input | 8 | Byte to send, sampled at the end of the acknowledge clock |
| busy | output | 1 | Slave is addressed and the transfer is not yet closed |

## Verification
The two events that can fall in the same cycle are the slave's own byte boundary and a bus condition. Both are provoked by the master model in the bench. A STOP or a repeated START is sent directly after an acknowledge, and a STOP is sent after only a few bits of a byte. The bench then judges that the condition wins: busy must drop, SDA must be free, and the next transfer must be decoded from its address byte. The address sweep covers all 128 addresses in turn. A match and a mismatch therefore meet the same ninth-clock decision, and the acknowledge is sampled at both ends of that SCL high phase.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // released, waiting for START (also used after mismatch)
      ST_ADDR,   // shifting in the address byte
      ST_AACK,   // driving the address acknowledge
      ST_RX,     // shifting in a data byte
      ST_RACK,   // driving the data acknowledge
      ST_TX,     // shifting out a data byte
      ST_TACK,   // sampling the master's acknowledge
      ST_HOLD    // master refused a byte; busy until STOP or START
   } slv_state_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_in};
         sda_q <= {sda_q[STAGES-2:0], sda_in};
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slv_shift.sv
module i2c_slv_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad_width
         $error("i2c_slv_shift: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load)     q <= load_val;
      else if (shift_en) q <= {q[W-2:0], bit_in};
   end
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
   import i2c_slv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_req,
   input  logic [DATA_W-1:0] tx_data,
   output logic              busy
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   generate
      if (ADDR_W + 1 != DATA_W) begin : g_bad_addr
         $error("i2c_slave_engine: address plus direction bit must fill one byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   slv_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic              is_read, m_ack;
   logic              sh_load, sh_shift;
   logic [DATA_W-1:0] sh_q;

   assign sh_load  = scl_fall && ((state == ST_AACK && is_read) ||
                                  (state == ST_TACK && m_ack));
   assign sh_shift = (scl_rise && (state == ST_ADDR || state == ST_RX)) ||
                     (scl_fall && state == ST_TX && cnt != CNT_LAST);

   i2c_slv_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(tx_data),
      .shift_en(sh_shift), .bit_in(sda_s), .q(sh_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         is_read  <= 1'b0;
         m_ack    <= 1'b0;
         sda_oe   <= 1'b0;
         rx_valid <= 1'b0;
         rx_data  <= '0;
         tx_req   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_req   <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise) cnt <= cnt + 1'b1;
                  if (scl_fall && cnt == CNT_FULL) begin
                     if (sh_q[DATA_W-1:1] == own_addr) begin
                        sda_oe  <= 1'b1;
                        is_read <= sh_q[0];
                        tx_req  <= sh_q[0];
                        state   <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_read) begin
                        sda_oe <= ~tx_data[DATA_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) cnt <= cnt + 1'b1;
                  if (scl_fall && cnt == CNT_FULL) begin
                     rx_valid <= 1'b1;
                     rx_data  <= sh_q;
                     sda_oe   <= 1'b1;
                     state    <= ST_RACK;
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TACK;
                     end else begin
                        sda_oe <= ~sh_q[DATA_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     m_ack  <= ~sda_s;
                     tx_req <= ~sda_s;
                  end
                  if (scl_fall) begin
                     cnt <= '0;
                     if (m_ack) begin
                        sda_oe <= ~tx_data[DATA_W-1];
                        state  <= ST_TX;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign busy = (state != ST_IDLE) && (state != ST_ADDR);
endmodule

// File: rtl/i2c_slave_engine_chk.sv
module i2c_slave_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic sda_oe,
   input logic busy,
   input logic rx_valid,
   input logic tx_req
);
   p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);
   p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   p_rx_addressed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> busy);
   p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));
   p_tx_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);
   p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!busy && !sda_oe));
   p_start_readdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!busy && !sda_oe));
endmodule

bind i2c_slave_engine i2c_slave_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .busy(busy),
   .rx_valid(rx_valid), .tx_req(tx_req)
);

// File: tb/tb_i2c_slave_engine.sv
module tb_i2c_slave_engine;
   localparam int QP = 8;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda_low = 1'b0;
   logic sda_oe, rx_valid, tx_req, busy;
   logic [7:0] rx_data;
   logic [7:0] tx_data = 8'h00;
   wire  sda_bus = ~(m_sda_low | sda_oe);

   int checks = 0, errors = 0;
   int rx_n = 0, tx_n = 0;
   logic [7:0] rx_log [0:63];

   always #5 clk = ~clk;

   i2c_slave_engine dut (
      .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_in(m_scl), .sda_in(sda_bus),
      .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_req(tx_req), .tx_data(tx_data), .busy(busy)
   );

   function automatic logic [7:0] pat(input int k);
      return 8'(k * 53 + 17);
   endfunction

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_log[rx_n % 64] = rx_data;
         rx_n++;
      end
      if (tx_req) begin
         tx_data = pat(tx_n);
         tx_n++;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (QP) @(negedge clk);
   endtask

   task automatic do_start();
      m_sda_low = 1'b0; m_scl = 1'b1; wq();
      m_sda_low = 1'b1; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic do_rstart();
      m_sda_low = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda_low = 1'b1; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic do_stop();
      m_sda_low = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda_low = 1'b0; wq();
   endtask

   // one SCL pulse; seen is low only if SDA was low at both ends of the high phase
   task automatic clk_bit(input logic drv, output logic seen);
      logic a, b;
      m_sda_low = ~drv; wq();
      m_scl = 1'b1;
      @(negedge clk); a = sda_bus;
      repeat (2 * QP - 2) @(negedge clk);
      b = sda_bus;
      @(negedge clk);
      m_scl = 1'b0; wq();
      seen = a | b;
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] v;
      logic [7:0] wdata [4];
      int base, rx0;
      wdata[0] = 8'h00; wdata[1] = 8'hFF; wdata[2] = 8'hA5; wdata[3] = 8'h3C;

      repeat (4) @(negedge clk);
      chk(sda_oe == 0 && busy == 0 && rx_valid == 0 && tx_req == 0, "R1",
          {sda_oe, busy, rx_valid, tx_req}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(sda_oe == 0 && busy == 0, "R1", {sda_oe, busy}, 0);

      // R2/R4/R7: sweep every address with the write direction
      for (int a = 0; a < 128; a++) begin
         do_start();
         wr_byte({7'(a), 1'b0}, ack);
         chk(ack == (7'(a) == OWN), "R2 R4 ack", ack, 7'(a) == OWN);
         chk(busy == (7'(a) == OWN), "R7 busy", busy, 7'(a) == OWN);
         do_stop();
         chk(busy == 0 && sda_oe == 0, "R7 stop", {busy, sda_oe}, 0);
      end
      chk(rx_n == 0, "R9 no rx on sweep", rx_n, 0);

      // R3: write transfer, each byte acked and strobed
      rx0 = rx_n;
      do_start();
      wr_byte({OWN, 1'b0}, ack);
      chk(ack, "R2 write addr", ack, 1);
      for (int j = 0; j < 4; j++) begin
         wr_byte(wdata[j], ack);
         chk(ack, "R3 data ack", ack, 1);
         chk(rx_n == rx0 + j + 1, "R3 strobe count", rx_n, rx0 + j + 1);
         chk(rx_log[(rx0 + j) % 64] == wdata[j], "R3 data", rx_log[(rx0 + j) % 64], wdata[j]);
      end
      do_stop();
      chk(busy == 0, "R7 after write", busy, 0);

      // R5/R6: read transfer, master acks three bytes then refuses the fourth
      base = tx_n;
      do_start();
      wr_byte({OWN, 1'b1}, ack);
      chk(ack, "R2 read addr", ack, 1);
      chk(tx_n == base + 1, "R5 first request", tx_n, base + 1);
      for (int j = 0; j < 4; j++) begin
         rd_byte(j < 3, v);
         chk(v == pat(base + j), "R5 tx byte", v, pat(base + j));
      end
      chk(tx_n == base + 4, "R6 no request after nack", tx_n, base + 4);
      chk(busy == 1, "R6 busy holds", busy, 1);
      rd_byte(1'b0, v);
      chk(v == 8'hFF, "R6 sda released", v, 8'hFF);
      chk(tx_n == base + 4, "R6 still no request", tx_n, base + 4);
      chk(busy == 1, "R6 busy until stop", busy, 1);
      do_stop();
      chk(busy == 0, "R7 stop after nack", busy, 0);

      // R8: repeated START switches from write to read
      rx0 = rx_n;
      base = tx_n;
      do_start();
      wr_byte({OWN, 1'b0}, ack);
      wr_byte(8'h66, ack);
      chk(ack && rx_n == rx0 + 1 && rx_log[rx0 % 64] == 8'h66, "R8 write before Sr",
          rx_log[rx0 % 64], 8'h66);
      do_rstart();
      chk(busy == 0, "R8 Sr clears busy", busy, 0);
      wr_byte({OWN, 1'b1}, ack);
      chk(ack, "R8 readdressed", ack, 1);
      rd_byte(1'b0, v);
      chk(v == pat(base), "R8 read after Sr", v, pat(base));
      do_stop();

      // R8: repeated START to a foreign address
      do_start();
      wr_byte({OWN, 1'b0}, ack);
      do_rstart();
      wr_byte({OWN ^ 7'h01, 1'b0}, ack);
      chk(!ack && busy == 0, "R8 Sr foreign addr", {ack, busy}, 0);
      do_stop();

      // R9: after a mismatch, even the own address as data is ignored
      rx0 = rx_n;
      do_start();
      wr_byte({OWN ^ 7'h40, 1'b0}, ack);
      wr_byte({OWN, 1'b0}, ack);
      chk(!ack, "R9 ignored after mismatch", ack, 0);
      chk(rx_n == rx0 && busy == 0, "R9 no strobe", rx_n, rx0);
      do_stop();

      // R9: STOP in the middle of a data byte
      do_start();
      wr_byte({OWN, 1'b0}, ack);
      for (int i = 0; i < 3; i++) clk_bit(1'b1, ack);
      do_stop();
      chk(busy == 0 && sda_oe == 0, "R9 mid-byte stop", {busy, sda_oe}, 0);
      rx0 = rx_n;
      do_start();
      wr_byte({OWN, 1'b0}, ack);
      wr_byte(8'h81, ack);
      chk(ack && rx_log[rx0 % 64] == 8'h81, "R9 recovers", rx_log[rx0 % 64], 8'h81);
      do_stop();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule